// File: doc/BRIEF.md
# Scanline Interrupt Down Counter

This block raises an interrupt after a fixed number of visible picture lines have gone by. A pulse arrives once per scanline, one clock wide, together with the number of that line and a flag that says whether rendering is on. The block counts down on each such line while it is armed. The line must be visible, which means line 0 to line 239, and rendering must be on. Lines outside that range, and lines seen while rendering is off, leave the count alone.

Software controls the block through two write strobes. The arm strobe turns counting on. The disarm strobe turns counting off and also withdraws any pending request. Either strobe forces both the count and its reload value to 0xBE (190). So an armed block reaches zero after 190 counted lines. On the 191st counted line it reloads from the reload value and raises its request. The request is a registered, active-high level. It stays high until a disarm write or a reset takes it down.

Top module: `scanline_irq`

## Requirements
- R1: After a synchronous reset, `irq_o` is 0, counting is off, and the count and reload value are both 0. Scanline pulses that arrive before the first arm write never raise `irq_o`.
- R2: A disarm write (`wr_disarm_i`) turns counting off, loads the count and the reload value with 0xBE, and drives `irq_o` to 0 from the next clock.
- R3: An arm write (`wr_arm_i`) turns counting on and loads the count and the reload value with 0xBE. It leaves `irq_o` at its present value.
- R4: A scanline pulse whose `line_i` is greater than 239 leaves the count unchanged.
- R5: A scanline pulse that arrives while `render_i` is 0 leaves the count unchanged.
- R6: On a counted line, a count above zero drops by one. A count of zero is reloaded from the reload value and sets `irq_o` one clock later. After an arm write, the 191st counted line raises `irq_o`, and none of the first 190 counted lines does.
- R7: Once set, `irq_o` stays at 1 through further lines and arm writes, until a disarm write or a reset.
- R8: If a write strobe and a scanline pulse occur in the same clock, the write takes effect and the pulse is not counted.
- R9: If both strobes are high in the same clock, the disarm write wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_pulse_i | input | 1 | One-clock pulse, once per scanline |
| line_i | input | 9 | Number of the line flagged by the pulse |
| render_i | input | 1 | Rendering is enabled |
| wr_disarm_i | input | 1 | Disarm register write strobe |
| wr_arm_i | input | 1 | Arm register write strobe |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
Every result appears one clock after the edge that takes in its stimulus. The count and the request are each a single register, so `irq_o` changes on the edge that samples the 191st counted pulse, and it drops on the edge that samples a disarm strobe. The bench changes its inputs on the falling edge and holds each pulse or strobe for exactly one rising edge. It reads `irq_o` on the next falling edge, half a period after the value is due. The count itself is hidden, so the bench checks it through the line number on which the request appears, with its arrival counted from the most recent write.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int CNT_W    = 8;
  localparam int LINE_W   = 9;
  localparam int LAST_VIS = 239;
  localparam logic [CNT_W-1:0] RELOAD_VAL = 8'hBE;
endpackage

// File: rtl/scanline_irq_line_qual.sv
module scanline_irq_line_qual #(
  parameter int LINE_W   = 9,
  parameter int LAST_VIS = 239
) (
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  output logic              qualify_o
);
  localparam logic [LINE_W-1:0] LastLine = LINE_W'(LAST_VIS);

  always_comb begin
    qualify_o = line_pulse_i && render_i && (line_i <= LastLine);
  end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int                CNT_W      = 8,
  parameter logic [CNT_W-1:0]  RELOAD_VAL = 8'hBE
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic qualify_i,
  input  logic wr_disarm_i,
  input  logic wr_arm_i,
  output logic fire_o
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] latch_q;
  logic             wr_any;
  logic             step;

  always_comb begin
    wr_any = wr_disarm_i || wr_arm_i;
    step   = qualify_i && armed_q && !wr_any;
    fire_o = step && (cnt_q == '0);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      latch_q <= '0;
    end else if (wr_disarm_i) begin
      armed_q <= 1'b0;
      cnt_q   <= RELOAD_VAL;
      latch_q <= RELOAD_VAL;
    end else if (wr_arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= RELOAD_VAL;
      latch_q <= RELOAD_VAL;
    end else if (step) begin
      if (cnt_q == '0) cnt_q <= latch_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_any |=> (cnt_q == RELOAD_VAL) && (latch_q == RELOAD_VAL)); // R2
  AST_ARM_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_arm_i && !wr_disarm_i) |=> armed_q); // R3
  AST_DISARM_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_disarm_i |=> !armed_q); // R9
  AST_HOLD_UNQUAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_any && !qualify_i) |=> $stable(cnt_q)); // R4
  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (step && cnt_q == '0) |=> cnt_q == $past(latch_q)); // R6
  AST_WRITE_PRIORITY: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_arm_i && qualify_i) |=> cnt_q == RELOAD_VAL); // R8
endmodule

// File: rtl/scanline_irq_flag.sv
module scanline_irq_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  input  logic wr_disarm_i,
  input  logic wr_arm_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)            irq_q <= 1'b0;
    else if (wr_disarm_i) irq_q <= 1'b0;
    else if (fire_i)      irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

  AST_DISARM_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_disarm_i |=> !irq_q); // R2
  AST_FIRE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_i && !wr_disarm_i) |=> irq_q); // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_q && !wr_disarm_i) |=> irq_q); // R7
  AST_ARM_KEEPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_arm_i && !wr_disarm_i && !fire_i) |=> $stable(irq_q)); // R3
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq
  import scanline_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              line_pulse_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_i,
  input  logic              wr_disarm_i,
  input  logic              wr_arm_i,
  output logic              irq_o
);
  logic qualify;
  logic fire;

  scanline_irq_line_qual #(
    .LINE_W  (LINE_W),
    .LAST_VIS(LAST_VIS)
  ) u_qual (
    .line_pulse_i(line_pulse_i),
    .line_i      (line_i),
    .render_i    (render_i),
    .qualify_o   (qualify)
  );

  scanline_irq_counter #(
    .CNT_W     (CNT_W),
    .RELOAD_VAL(RELOAD_VAL)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .qualify_i  (qualify),
    .wr_disarm_i(wr_disarm_i),
    .wr_arm_i   (wr_arm_i),
    .fire_o     (fire)
  );

  scanline_irq_flag u_flag (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fire_i     (fire),
    .wr_disarm_i(wr_disarm_i),
    .wr_arm_i   (wr_arm_i),
    .irq_o      (irq_o)
  );

  AST_OFFLINE_NO_FIRE: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_pulse_i && line_i > 9'd239) |-> !fire); // R4
  AST_DARK_NO_FIRE: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_pulse_i && !render_i) |-> !fire); // R5
endmodule

// File: tb/scanline_irq_tb.sv
module scanline_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pulse = 1'b0;
  logic [8:0] line = '0;
  logic       render = 1'b0;
  logic       wr_dis = 1'b0;
  logic       wr_arm = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scanline_irq u_dut (
    .clk_i(clk), .rst_i(rst), .line_pulse_i(pulse), .line_i(line),
    .render_i(render), .wr_disarm_i(wr_dis), .wr_arm_i(wr_arm), .irq_o(irq)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  task automatic line_pulse(input int ln, input logic rend);
    @(negedge clk);
    pulse = 1'b1; line = 9'(ln); render = rend;
    @(negedge clk);
    pulse = 1'b0; render = 1'b0;
  endtask

  task automatic lines(input int n, input int ln, input logic rend);
    for (int i = 0; i < n; i++) line_pulse(ln + (i % 10), rend);
  endtask

  task automatic write(input logic dis, input logic arm, input logic with_line);
    @(negedge clk);
    wr_dis = dis; wr_arm = arm;
    if (with_line) begin pulse = 1'b1; line = 9'd5; render = 1'b1; end
    @(negedge clk);
    wr_dis = 1'b0; wr_arm = 1'b0; pulse = 1'b0; render = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset", 1'b0);
    lines(300, 0, 1'b1);
    check("R1 unarmed lines", 1'b0);
  endtask

  task automatic t_basic;
    write(1'b0, 1'b1, 1'b0);
    lines(190, 0, 1'b1);
    check("R6 before expiry", 1'b0);
    line_pulse(100, 1'b1);
    check("R6 expiry", 1'b1);
    lines(50, 0, 1'b1);
    check("R7 sticky over lines", 1'b1);
    write(1'b0, 1'b1, 1'b0);
    check("R3 arm keeps irq", 1'b1);
    write(1'b1, 1'b0, 1'b0);
    check("R2 disarm clears", 1'b0);
    lines(300, 0, 1'b1);
    check("R2 disarmed no count", 1'b0);
  endtask

  task automatic t_offscreen;
    write(1'b0, 1'b1, 1'b0);
    lines(190, 230, 1'b1);
    line_pulse(240, 1'b1);
    line_pulse(261, 1'b1);
    lines(5, 245, 1'b1);
    check("R4 invisible lines ignored", 1'b0);
    line_pulse(239, 1'b1);
    check("R4 line 239 counts", 1'b1);
    write(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_dark;
    write(1'b0, 1'b1, 1'b0);
    lines(190, 0, 1'b1);
    lines(20, 0, 1'b0);
    check("R5 render off ignored", 1'b0);
    line_pulse(0, 1'b1);
    check("R5 count resumes", 1'b1);
    write(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    write(1'b0, 1'b1, 1'b0);
    lines(190, 0, 1'b1);
    write(1'b0, 1'b1, 1'b1);
    check("R8 arm beats line", 1'b0);
    lines(190, 0, 1'b1);
    check("R8 count restarted", 1'b0);
    line_pulse(3, 1'b1);
    check("R8 fires after restart", 1'b1);
    write(1'b1, 1'b0, 1'b1);
    check("R8 disarm beats line", 1'b0);
    write(1'b0, 1'b1, 1'b0);
    lines(100, 0, 1'b1);
    write(1'b0, 1'b1, 1'b0);
    lines(190, 0, 1'b1);
    check("R3 rearm reloads", 1'b0);
    line_pulse(7, 1'b1);
    check("R3 rearm fires", 1'b1);
    write(1'b1, 1'b1, 1'b0);
    check("R9 both writes clear", 1'b0);
    lines(200, 0, 1'b1);
    check("R9 disarm wins", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_offscreen();
    t_dark();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule